// File: doc/BRIEF.md
# Clock Phase Retry Controller

This block runs after a board reset to bring slave clocks into phase. Each slave reports a 32-bit status word, and one bit of that word shows whether its clock is locked in phase. For each selected slave the controller reads that bit. If the clock is out of phase, it sends a one-cycle clock-reset request to the board controller. It then waits a programmable settle time and reads the bit again.

A reset only has some chance of fixing the phase, so the controller tries a bounded number of times for each slave. If a slave is still out of phase after its last allowed request, the controller stops and raises an error. A later start or manual retry command runs the whole pass again, for example after a slave has been reset on its own. By default only slave 3 is checked, because its clock may sit half a period away from the clock of slave 0. A non-zero mask selects any set of slaves instead.

Top module: `phase_retry_ctrl`

## Requirements
- R1: After reset, `done_o`, `err_o` and `clk_rst_req_o` are low and `attempts_o` is zero.
- R2: In the idle state, a high `start_i` or `retry_i` starts a new pass. The start clears `attempts_o`, `done_o` and `err_o`, and the two inputs have the same effect.
- R3: Slave s reports on `status_words_i[32*s+31:32*s]`. Only bit 12 of that word is read, and a 1 there means in phase. All other bits have no effect.
- R4: When `slave_mask_i` is zero, only slave 3 is selected. Otherwise bit s of the mask selects slave s. Selected slaves are handled one after another in ascending index order.
- R5: For each reset request on a selected, out-of-phase slave, `clk_rst_req_o` is high for exactly one cycle and `clk_rst_sel_o` is one-hot on that slave. `attempts_o` then counts one more request for the current pass.
- R6: After a request, the status bit is read again `settle_i`+2 cycles after the request. Two back-to-back requests to the same slave are therefore `settle_i`+2 cycles apart.
- R7: No slave receives more than 10 requests in a pass. If the slave is still out of phase when read after its tenth request, `err_o` rises and no further requests follow.
- R8: When every selected slave reads in phase, `done_o` rises. A slave that is already in phase receives no request.
- R9: `start_i` and `retry_i` are ignored while a pass is running.
- R10: The limit of 10 requests applies to each slave separately. `attempts_o` is the total over all slaves in the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a correction pass |
| retry_i | input | 1 | Manual retry command; restarts a pass |
| slave_mask_i | input | 4 | Slave select; zero selects slave 3 only |
| status_words_i | input | 128 | Four 32-bit slave status words; slave s in bits 32s+31:32s |
| settle_i | input | 16 | Number of wait cycles after a request, minus one |
| clk_rst_req_o | output | 1 | One-cycle clock reset request |
| clk_rst_sel_o | output | 4 | One-hot slave targeted by the request |
| done_o | output | 1 | All selected slaves read in phase |
| err_o | output | 1 | A slave stayed out of phase after its last try |
| attempts_o | output | 6 | Requests issued in the current pass |

## Verification
The assertions assume that `settle_i` and `slave_mask_i` stay stable for the whole of a pass. They also assume that a status bit changes only in answer to a request. The bench meets these assumptions by writing the mask and settle value before each start pulse and by leaving them unchanged until `done_o` or `err_o`. Its phase-lock model flips a slave's bit only on the negative edge after that slave's request, and only once a chosen number of requests has been reached; that number is sometimes drawn at random.

// File: rtl/phase_retry_ctrl.sv
module phase_retry_ctrl #(
  parameter int NSLV      = 4,
  parameter int WORD_W    = 32,
  parameter int LOCK_BIT  = 12,
  parameter int MAX_TRIES = 10,
  parameter int SETTLE_W  = 16,
  parameter logic [NSLV-1:0] DEF_MASK = 4'b1000,
  localparam int IDX_W    = (NSLV > 1) ? $clog2(NSLV) : 1,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1),
  localparam int CNT_W    = $clog2(MAX_TRIES * NSLV + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   retry_i,
  input  logic [NSLV-1:0]        slave_mask_i,
  input  logic [NSLV*WORD_W-1:0] status_words_i,
  input  logic [SETTLE_W-1:0]    settle_i,
  output logic                   clk_rst_req_o,
  output logic [NSLV-1:0]        clk_rst_sel_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [CNT_W-1:0]       attempts_o
);

  localparam logic [2:0] S_IDLE   = 3'd0;
  localparam logic [2:0] S_SCAN   = 3'd1;
  localparam logic [2:0] S_SETTLE = 3'd2;

  logic [2:0]          state;
  logic [IDX_W-1:0]    idx;
  logic [TRY_W-1:0]    tries;
  logic [SETTLE_W-1:0] wait_cnt;
  logic [NSLV-1:0]     locked;
  logic [NSLV-1:0]     eff_mask;
  logic                trig, cur_skip, last_slv, at_limit;

  for (genvar g = 0; g < NSLV; g++) begin : g_lock
    assign locked[g] = status_words_i[g*WORD_W + LOCK_BIT];
  end

  assign eff_mask = (|slave_mask_i) ? slave_mask_i : DEF_MASK;
  assign trig     = start_i | retry_i;
  assign cur_skip = !eff_mask[idx] || locked[idx];
  assign last_slv = (idx == IDX_W'(NSLV - 1));
  assign at_limit = (tries == TRY_W'(MAX_TRIES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      idx           <= '0;
      tries         <= '0;
      wait_cnt      <= '0;
      attempts_o    <= '0;
      done_o        <= 1'b0;
      err_o         <= 1'b0;
      clk_rst_req_o <= 1'b0;
      clk_rst_sel_o <= '0;
    end else begin
      clk_rst_req_o <= 1'b0;
      clk_rst_sel_o <= '0;
      case (state)
        S_IDLE: begin
          if (trig) begin
            state      <= S_SCAN;
            idx        <= '0;
            tries      <= '0;
            attempts_o <= '0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
          end
        end
        S_SCAN: begin
          if (cur_skip) begin
            tries <= '0;
            if (last_slv) begin
              done_o <= 1'b1;
              state  <= S_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end else if (at_limit) begin
            err_o <= 1'b1;
            state <= S_IDLE;
          end else begin
            clk_rst_req_o <= 1'b1;
            clk_rst_sel_o <= NSLV'(1) << idx;
            tries         <= tries + 1'b1;
            attempts_o    <= attempts_o + 1'b1;
            wait_cnt      <= settle_i;
            state         <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (wait_cnt == '0) state <= S_SCAN;
          else wait_cnt <= wait_cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module phase_retry_ctrl_chk #(
  parameter int NSLV      = 4,
  parameter int MAX_TRIES = 10,
  parameter int TRY_W     = 4,
  parameter int CNT_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             retry_i,
  input logic             req,
  input logic [NSLV-1:0]  sel,
  input logic             done,
  input logic             err,
  input logic [CNT_W-1:0] attempts,
  input logic [2:0]       state,
  input logic [TRY_W-1:0] tries,
  input logic [NSLV-1:0]  eff_mask
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) req |=> !req); // R5
  AST_SEL_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n) req |-> ($countones(sel) == 1 && (sel & ~eff_mask) == '0)); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R7
  AST_QUIET_FINISHED: assert property (@(posedge clk) disable iff (!rst_n) (done || err) |-> !req); // R8
  AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> tries == TRY_W'(MAX_TRIES)); // R7
  AST_TRIES_CAP: assert property (@(posedge clk) disable iff (!rst_n) tries <= TRY_W'(MAX_TRIES)); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (state == 3'd0 && (start_i || retry_i)) |=> (attempts == '0 && !done && !err)); // R2
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n) (state != 3'd0 && (start_i || retry_i)) |=> attempts >= $past(attempts)); // R9

endmodule

bind phase_retry_ctrl phase_retry_ctrl_chk #(
  .NSLV(NSLV), .MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .retry_i(retry_i),
  .req(clk_rst_req_o), .sel(clk_rst_sel_o), .done(done_o), .err(err_o),
  .attempts(attempts_o), .state(state), .tries(tries), .eff_mask(eff_mask)
);

// File: tb/phase_retry_ctrl_tb.sv
module phase_retry_ctrl_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         retry_i = 1'b0;
  logic [3:0]   mask = 4'b0000;
  logic [127:0] stat;
  logic [15:0]  settle = 16'd3;
  logic         req;
  logic [3:0]   sel;
  logic         done, err;
  logic [5:0]   attempts;

  logic [3:0]   lock;
  logic [31:0]  noise [4];
  int           fix_after [4];
  int           pulses [4];
  int           first_slave, last_slave, last_cyc, cyc;
  int           spacing_bad, width_bad;
  logic         prev_req;
  int           total, bad;

  always #5 clk = ~clk;

  phase_retry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .retry_i(retry_i),
    .slave_mask_i(mask), .status_words_i(stat), .settle_i(settle),
    .clk_rst_req_o(req), .clk_rst_sel_o(sel), .done_o(done), .err_o(err),
    .attempts_o(attempts)
  );

  always_comb begin
    for (int s = 0; s < 4; s++)
      stat[s*32 +: 32] = (noise[s] & ~32'h1000) | (lock[s] ? 32'h1000 : 32'h0);
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (req) begin
      int s;
      s = 0;
      for (int k = 0; k < 4; k++) if (sel[k]) s = k;
      if (prev_req) width_bad = width_bad + 1;
      if (last_slave == s && (cyc - last_cyc) != int'(settle) + 2) spacing_bad = spacing_bad + 1;
      if (first_slave < 0) first_slave = s;
      last_slave = s;
      last_cyc = cyc;
      pulses[s] = pulses[s] + 1;
      if (fix_after[s] != 0 && pulses[s] == fix_after[s]) lock[s] = 1'b1;
    end
    prev_req = req;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [3:0] lk, input int f0, input int f3, input logic [15:0] st, input logic [3:0] m);
    lock = lk;
    fix_after[0] = f0; fix_after[1] = 0; fix_after[2] = 0; fix_after[3] = f3;
    for (int s = 0; s < 4; s++) pulses[s] = 0;
    first_slave = -1; last_slave = -1;
    spacing_bad = 0; width_bad = 0;
    settle = st; mask = m;
  endtask

  task automatic kick(input bit use_retry);
    @(negedge clk);
    if (use_retry) retry_i = 1'b1; else start_i = 1'b1;
    @(negedge clk);
    retry_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic wait_finish();
    int n;
    n = 0;
    while (!(done || err) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n < 5000, "R8 pass finishes", n, 5000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!done && !err && !req, "R1 flags low", {done, err, req}, 0);
    check(attempts == 0, "R1 attempts", attempts, 0);
  endtask

  task automatic t_default_mask();
    for (int s = 0; s < 4; s++) noise[s] = 32'hFFFF_FFFF;
    setup(4'b0000, 0, 3, 16'd3, 4'b0000);
    kick(0);
    wait_finish();
    check(done && !err, "R4 default pass done", done, 1);
    check(attempts == 3, "R5 attempts", attempts, 3);
    check(pulses[3] == 3 && pulses[0] == 0, "R4 only slave 3 pulsed", pulses[0], 0);
    check(width_bad == 0, "R5 pulse width", width_bad, 0);
    check(spacing_bad == 0, "R6 request spacing", spacing_bad, 0);
  endtask

  task automatic t_in_phase();
    for (int s = 0; s < 4; s++) noise[s] = 32'h0;
    setup(4'b1000, 0, 0, 16'd2, 4'b0000);
    kick(0);
    wait_finish();
    check(done && attempts == 0, "R8 no request when locked", attempts, 0);
    check(pulses[3] == 0, "R3 lock bit read", pulses[3], 0);
  endtask

  task automatic t_limit();
    noise[3] = 32'hFFFF_EFFF;
    setup(4'b0000, 0, 0, 16'd1, 4'b0000);
    kick(0);
    wait_finish();
    check(err && !done, "R7 err raised", err, 1);
    check(attempts == 10 && pulses[3] == 10, "R7 ten requests", pulses[3], 10);
    repeat (50) @(negedge clk);
    check(pulses[3] == 10 && err, "R7 stays stopped", pulses[3], 10);
  endtask

  task automatic t_retry();
    setup(4'b0000, 0, 2, 16'd4, 4'b0000);
    kick(1);
    @(negedge clk);
    check(!err, "R2 retry clears err", err, 0);
    wait_finish();
    check(done && !err && attempts == 2, "R2 retry pass", attempts, 2);
  endtask

  task automatic t_two_slaves();
    setup(4'b0000, 10, 3, 16'd0, 4'b1001);
    kick(0);
    wait_finish();
    check(done && !err, "R10 per-slave limit", err, 0);
    check(attempts == 13, "R10 total attempts", attempts, 13);
    check(first_slave == 0 && pulses[0] == 10 && pulses[3] == 3, "R4 ascending order", first_slave, 0);
    check(pulses[1] == 0 && pulses[2] == 0, "R4 unselected untouched", pulses[1] + pulses[2], 0);
  endtask

  task automatic t_busy_ignore();
    setup(4'b0000, 0, 5, 16'd20, 4'b0000);
    kick(0);
    while (pulses[3] < 2) @(negedge clk);
    kick(0);
    kick(1);
    wait_finish();
    check(attempts == 5 && pulses[3] == 5, "R9 start ignored while busy", attempts, 5);
  endtask

  task automatic t_random();
    for (int i = 0; i < 5; i++) begin
      int fa, expp;
      logic [15:0] st;
      fa = $urandom_range(1, 13);
      st = 16'($urandom_range(0, 7));
      expp = (fa > 10) ? 10 : fa;
      setup(4'b0000, 0, (fa > 10) ? 0 : fa, st, 4'b0000);
      kick(i % 2 == 1);
      wait_finish();
      check(pulses[3] == expp && attempts == expp, "R7 random tries", pulses[3], expp);
      check(err == (fa > 10), "R7 random err", err, fa > 10);
      check(spacing_bad == 0, "R6 random spacing", spacing_bad, 0);
    end
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; prev_req = 1'b0;
    for (int s = 0; s < 4; s++) noise[s] = 32'h0;
    setup(4'b0000, 0, 0, 16'd3, 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_mask();
    t_in_phase();
    t_limit();
    t_retry();
    t_two_slaves();
    t_busy_ignore();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule